// File: doc/BRIEF.md
# Dual-Channel Indirect Register Front End

This block is the bus-facing register logic of a two-channel serial controller. A host reaches it through an 8-bit data bus, a chip select, separate read and write strobes and two address lines. One address line picks the channel and the other picks between the control path and the data path. Data-path accesses go straight to the selected channel's data holding register.

Control registers are reached indirectly, through one pointer shared by both channels. The host first writes register 0, which loads the pointer. The next control access then uses the register the pointer names. That access returns the pointer to 0, so the next control write lands in register 0 again.

Most control registers exist once per channel. The interrupt vector and the master interrupt control register are single shared copies. The block combines per-channel pending sources with per-channel enables and the master enable to drive an active-high interrupt output. It pulses a change strobe whenever that output toggles. On channel B, a read of the vector returns the vector with a priority code of the highest pending source merged into it.

Top module: `scc_regfront`

## Requirements
- R1: Address bit 0 selects the channel (0 = A, 1 = B) and address bit 1 selects the path (0 = control, 1 = data). An access takes place only in a cycle where `cs` is high; the write happens at the clock edge and read data is valid combinationally in the same cycle.
- R2: A data write stores the byte in the selected channel's data holding register, and a data read returns that channel's last stored byte. Data accesses neither use nor change the register pointer.
- R3: After reset the pointer is 0, all per-channel and shared registers are 0x00, `irq` is low and `irq_chg` stays low. `rdata` is 0x00 whenever no read is in progress.
- R4: A control write while the pointer is 0 loads pointer bits 2:0 from wdata[2:0]. Pointer bit 3 is set only when wdata[5:3] equals 3'b001; any other command field leaves bit 3 clear.
- R5: After any control read, and after a control write while the pointer is non-zero, the pointer returns to 0.
- R6: Register 2 (interrupt vector) is a single copy; a write to it through either channel address updates it.
- R7: A read of register 2 through channel A returns the stored vector. Through channel B it returns the vector with bits 3:1 replaced by the code of the highest enabled pending source: A-rx 110, A-tx 100, A-ext 101, B-rx 010, B-tx 000, B-ext 001 (highest priority first), or 011 when none.
- R8: Register 9 (master interrupt control) is a single copy, written and read back through either channel. Its bit 3 is the master interrupt enable.
- R9: Every other control register is per channel, selected by address bit 0. Registers 1, 12, 13 and 15 read back their written value. Register 0 reads {5'b0, pending[2:0]} of its channel. All other register numbers read 0x00.
- R10: `irq` is high exactly when the master enable is set and some source is both pending and enabled. It follows its cause with one register stage. `src_pend` bits [2:0] belong to channel A and [5:3] to channel B, ordered ext, tx, rx from bit 0. Register 1 bits 2:0 of each channel enable those sources in the same order.
- R11: `irq_chg` is a one-cycle pulse, high in exactly the cycle in which `irq` takes a new level.
- R12: With `cs` low, strobes have no effect. With read and write strobes both high, only the write is performed and `rdata` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Bit 0 channel, bit 1 control/data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| src_pend | input | 6 | Pending interrupt sources, channel A low |
| irq | output | 1 | Interrupt output, active high |
| irq_chg | output | 1 | One-cycle pulse on each `irq` transition |

## Verification
The bench builds the block with the package defaults: an 8-bit bus, sixteen registers per channel behind a 4-bit pointer, and three interrupt sources per channel. These values put every pointer value within reach, including the point-high range 8 to 15 and the unimplemented numbers that read zero. They also allow all six sources to be set one at a time, which walks the channel-B vector code through each priority step and its no-pending value.

// File: rtl/scc_pkg.sv
package scc_pkg;

    localparam int DW   = 8;
    localparam int NREG = 16;
    localparam int PW   = $clog2(NREG);
    localparam int NCH  = 2;
    localparam int NSRC = 3;
    localparam int NACT = NCH * NSRC;

    localparam logic [PW-1:0] REG_STAT = PW'(0);
    localparam logic [PW-1:0] REG_IEN  = PW'(1);
    localparam logic [PW-1:0] REG_VEC  = PW'(2);
    localparam logic [PW-1:0] REG_MIC  = PW'(9);

    // registers of a channel bank that read back their written value
    localparam logic [NREG-1:0] RB_MASK = 16'b1011_0000_0000_0010;

    localparam logic [2:0] CMD_PT_HI = 3'b001;
    localparam logic [2:0] CODE_NONE = 3'b011;
    localparam int         MIE_BIT   = 3;

    localparam int SRC_EXT = 0;
    localparam int SRC_TX  = 1;
    localparam int SRC_RX  = 2;

    typedef struct packed {
        logic ch;
        logic ctl_rd;
        logic ctl_wr;
        logic dat_rd;
        logic dat_wr;
    } acc_t;

    function automatic acc_t decode(input logic cs, input logic rd,
                                    input logic wr, input logic [1:0] a);
        acc_t r;
        logic we, re;
        we = cs & wr;
        re = cs & rd & ~wr;
        r.ch     = a[0];
        r.ctl_wr = we & ~a[1];
        r.dat_wr = we &  a[1];
        r.ctl_rd = re & ~a[1];
        r.dat_rd = re &  a[1];
        return r;
    endfunction

    function automatic logic [PW-1:0] next_ptr(input logic [DW-1:0] v);
        logic [PW-1:0] p;
        p = '0;
        p[2:0] = v[2:0];
        p[PW-1] = (v[5:3] == CMD_PT_HI);
        return p;
    endfunction

    function automatic logic [2:0] prio_code(input logic [NACT-1:0] act);
        logic [2:0] c;
        if (act[SRC_RX])             c = 3'b110;
        else if (act[SRC_TX])        c = 3'b100;
        else if (act[SRC_EXT])       c = 3'b101;
        else if (act[NSRC+SRC_RX])   c = 3'b010;
        else if (act[NSRC+SRC_TX])   c = 3'b000;
        else if (act[NSRC+SRC_EXT])  c = 3'b001;
        else                         c = CODE_NONE;
        return c;
    endfunction

    function automatic logic [DW-1:0] vec_merge(input logic [DW-1:0] v,
                                                input logic [2:0] code);
        logic [DW-1:0] r;
        r = v;
        r[3:1] = code;
        return r;
    endfunction

endpackage

// File: rtl/scc_ptr.sv
module scc_ptr
    import scc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic          ctl_rd,
    input  logic [DW-1:0] wdata,
    output logic [PW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ctl_wr) begin
            if (ptr == REG_STAT) ptr <= next_ptr(wdata);
            else                 ptr <= '0;
        end else if (ctl_rd) begin
            ptr <= '0;
        end
    end

endmodule

// File: rtl/scc_chan_bank.sv
module scc_chan_bank
    import scc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we_ctl,
    input  logic            we_dat,
    input  logic [PW-1:0]   idx,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] pend,
    output logic [DW-1:0]   ctl_rdata,
    output logic [DW-1:0]   dat_rdata,
    output logic [NSRC-1:0] ien
);

    logic [DW-1:0] wreg [NREG];
    logic [DW-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) wreg[i] <= '0;
            hold <= '0;
        end else begin
            if (we_ctl) wreg[idx] <= wdata;
            if (we_dat) hold      <= wdata;
        end
    end

    always_comb begin
        if (idx == REG_STAT)  ctl_rdata = {{(DW-NSRC){1'b0}}, pend};
        else if (RB_MASK[idx]) ctl_rdata = wreg[idx];
        else                  ctl_rdata = '0;
    end

    assign dat_rdata = hold;
    assign ien       = wreg[REG_IEN][NSRC-1:0];

endmodule

// File: rtl/scc_irq.sv
module scc_irq
    import scc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NACT-1:0] act,
    input  logic            mie,
    output logic            irq,
    output logic            irq_chg,
    output logic [2:0]      code
);

    logic level;

    assign level = mie & (|act);
    assign code  = prio_code(act);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            irq_chg <= 1'b0;
        end else begin
            irq     <= level;
            irq_chg <= (level != irq);
        end
    end

endmodule

// File: rtl/scc_regfront.sv
module scc_regfront
    import scc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs,
    input  logic            rd,
    input  logic            wr,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NACT-1:0] src_pend,
    output logic            irq,
    output logic            irq_chg
);

    acc_t          acc;
    logic [PW-1:0] ptr;
    logic [DW-1:0] vec;
    logic [DW-1:0] mic;
    logic          shared_hit;
    logic [2:0]    code;
    logic [NACT-1:0] act;

    logic [DW-1:0]   ctl_rd_ch [NCH];
    logic [DW-1:0]   dat_rd_ch [NCH];
    logic [NSRC-1:0] ien_ch    [NCH];

    assign acc        = decode(cs, rd, wr, addr);
    assign shared_hit = (ptr == REG_VEC) || (ptr == REG_MIC);

    scc_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ctl_wr (acc.ctl_wr),
        .ctl_rd (acc.ctl_rd),
        .wdata  (wdata),
        .ptr    (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec <= '0;
            mic <= '0;
        end else if (acc.ctl_wr) begin
            if (ptr == REG_VEC) vec <= wdata;
            if (ptr == REG_MIC) mic <= wdata;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = (acc.ch == 1'(c));

        scc_chan_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .we_ctl    (acc.ctl_wr & sel & ~shared_hit),
            .we_dat    (acc.dat_wr & sel),
            .idx       (ptr),
            .wdata     (wdata),
            .pend      (src_pend[c*NSRC +: NSRC]),
            .ctl_rdata (ctl_rd_ch[c]),
            .dat_rdata (dat_rd_ch[c]),
            .ien       (ien_ch[c])
        );

        assign act[c*NSRC +: NSRC] = src_pend[c*NSRC +: NSRC] & ien_ch[c];
    end

    scc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .mie     (mic[MIE_BIT]),
        .irq     (irq),
        .irq_chg (irq_chg),
        .code    (code)
    );

    always_comb begin
        rdata = '0;
        if (acc.dat_rd) begin
            rdata = dat_rd_ch[acc.ch];
        end else if (acc.ctl_rd) begin
            if (ptr == REG_VEC)      rdata = acc.ch ? vec_merge(vec, code) : vec;
            else if (ptr == REG_MIC) rdata = mic;
            else                     rdata = ctl_rd_ch[acc.ch];
        end
    end

endmodule

// File: rtl/scc_regfront_chk.sv
module scc_regfront_chk
    import scc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cs,
    input logic          rd,
    input logic          wr,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata,
    input logic [PW-1:0] ptr,
    input logic [DW-1:0] mic,
    input logic          irq,
    input logic          irq_chg
);

    AST_PTR_CLR_RD: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && !wr && !addr[1]) |=> (ptr == '0)); // R5

    AST_PTR_CLR_WR: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && !addr[1] && ptr != '0) |=> (ptr == '0)); // R5

    AST_POINT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && !addr[1] && ptr == '0 && wdata[5:3] == CMD_PT_HI)
        |=> (ptr == {1'b1, $past(wdata[2:0])})); // R4

    AST_DATA_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (cs && addr[1]) |=> $stable(ptr)); // R2

    AST_CHG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        irq_chg |-> (irq != $past(irq))); // R11

    AST_IRQ_NEEDS_MIE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mic[MIE_BIT])); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (ptr == '0 && !irq && !irq_chg)); // R3

endmodule

bind scc_regfront scc_regfront_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .rd      (rd),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .ptr     (ptr),
    .mic     (mic),
    .irq     (irq),
    .irq_chg (irq_chg)
);

// File: tb/test_scc_regfront.sv
module test_scc_regfront;
    import scc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 45;
    // entry: {req[3:0], is_read, addr[1:0], wdata[7:0], expected[7:0]}
    localparam logic [22:0] VECS [NV] = '{
        {4'd4, 1'b0, 2'd0, 8'h01, 8'h00},
        {4'd9, 1'b0, 2'd0, 8'h05, 8'h00},
        {4'd4, 1'b0, 2'd1, 8'h01, 8'h00},
        {4'd9, 1'b0, 2'd1, 8'h02, 8'h00},
        {4'd4, 1'b0, 2'd0, 8'h0C, 8'h00},
        {4'd9, 1'b0, 2'd0, 8'hAA, 8'h00},
        {4'd4, 1'b0, 2'd0, 8'h01, 8'h00},
        {4'd9, 1'b1, 2'd0, 8'h00, 8'h05},
        {4'd4, 1'b0, 2'd1, 8'h01, 8'h00},
        {4'd1, 1'b1, 2'd1, 8'h00, 8'h02},
        {4'd4, 1'b0, 2'd1, 8'h0C, 8'h00},
        {4'd9, 1'b1, 2'd1, 8'h00, 8'h00},
        {4'd4, 1'b0, 2'd0, 8'h02, 8'h00},
        {4'd6, 1'b0, 2'd0, 8'h5A, 8'h00},
        {4'd4, 1'b0, 2'd1, 8'h02, 8'h00},
        {4'd7, 1'b1, 2'd1, 8'h00, 8'h56},
        {4'd4, 1'b0, 2'd0, 8'h02, 8'h00},
        {4'd7, 1'b1, 2'd0, 8'h00, 8'h5A},
        {4'd4, 1'b0, 2'd0, 8'h09, 8'h00},
        {4'd8, 1'b0, 2'd1, 8'h08, 8'h00},
        {4'd4, 1'b0, 2'd1, 8'h09, 8'h00},
        {4'd8, 1'b1, 2'd0, 8'h00, 8'h08},
        {4'd4, 1'b0, 2'd1, 8'h0D, 8'h00},
        {4'd9, 1'b0, 2'd1, 8'h77, 8'h00},
        {4'd4, 1'b0, 2'd1, 8'h0D, 8'h00},
        {4'd4, 1'b1, 2'd1, 8'h00, 8'h77},
        {4'd4, 1'b0, 2'd0, 8'h05, 8'h00},
        {4'd9, 1'b0, 2'd0, 8'h33, 8'h00},
        {4'd4, 1'b0, 2'd0, 8'h05, 8'h00},
        {4'd9, 1'b1, 2'd0, 8'h00, 8'h00},
        {4'd2, 1'b0, 2'd2, 8'h11, 8'h00},
        {4'd2, 1'b0, 2'd3, 8'h22, 8'h00},
        {4'd2, 1'b1, 2'd2, 8'h00, 8'h11},
        {4'd2, 1'b1, 2'd3, 8'h00, 8'h22},
        {4'd4, 1'b0, 2'd0, 8'h01, 8'h00},
        {4'd2, 1'b0, 2'd2, 8'h99, 8'h00},
        {4'd2, 1'b1, 2'd0, 8'h00, 8'h05},
        {4'd2, 1'b1, 2'd2, 8'h00, 8'h99},
        {4'd4, 1'b0, 2'd0, 8'h21, 8'h00},
        {4'd4, 1'b0, 2'd0, 8'h06, 8'h00},
        {4'd4, 1'b0, 2'd0, 8'h01, 8'h00},
        {4'd4, 1'b1, 2'd0, 8'h00, 8'h06},
        {4'd5, 1'b1, 2'd0, 8'h00, 8'h00},
        {4'd4, 1'b0, 2'd0, 8'h0C, 8'h00},
        {4'd9, 1'b1, 2'd0, 8'h00, 8'hAA}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cs, rd, wr;
    logic [1:0]    addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [NACT-1:0] src_pend;
    logic          irq, irq_chg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scc_regfront i_scc_regfront (
        .clk      (clk),
        .rst      (rst),
        .cs       (cs),
        .rd       (rd),
        .wr       (wr),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .src_pend (src_pend),
        .irq      (irq),
        .irq_chg  (irq_chg)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic access(input bit is_rd, input logic [1:0] a, input logic [7:0] d,
                          output logic [7:0] got);
        @(negedge clk);
        cs = 1'b1; rd = is_rd; wr = !is_rd; addr = a; wdata = d;
        #1 got = rdata;
        @(posedge clk);
        #1 cs = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] g;
        access(1'b0, a, d, g);
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] g);
        access(1'b1, a, 8'h00, g);
    endtask

    task automatic sample_irq(input string req, input logic e_irq, input logic e_chg);
        @(negedge clk);
        #1;
        check(req, {7'b0, irq}, {7'b0, e_irq});
        check(req, {7'b0, irq_chg}, {7'b0, e_chg});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        rst = 1'b1; cs = 1'b0; rd = 1'b0; wr = 1'b0;
        addr = '0; wdata = '0; src_pend = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R3: reset state
        @(negedge clk); #1;
        check("R3 irq", {7'b0, irq}, 8'h00);
        check("R3 irq_chg", {7'b0, irq_chg}, 8'h00);
        check("R3 idle rdata", rdata, 8'h00);

        // table walk (R1 R2 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            access(VECS[i][18], VECS[i][17:16], VECS[i][15:8], g);
            if (VECS[i][18]) begin
                checks++;
                if (g !== VECS[i][7:0]) begin
                    errors++;
                    $display("FAIL R%0d (entry %0d): got %h expected %h",
                             VECS[i][22:19], i, g, VECS[i][7:0]);
                end
            end
        end

        // state now: A ien=110, B ien=010, MIE set, vector 5A
        // R10 R11: A tx pending raises irq with one strobe
        @(negedge clk); src_pend = 6'b000_010;
        sample_irq("R10 R11 rise", 1'b1, 1'b1);
        sample_irq("R11 strobe one cycle", 1'b1, 1'b0);

        // R7: channel B vector codes
        wr_reg(2'd1, 8'h02); rd_reg(2'd1, g); check("R7 A-tx code", g, 8'h58);
        @(negedge clk); src_pend = 6'b000_110;
        wr_reg(2'd1, 8'h02); rd_reg(2'd1, g); check("R7 A-rx priority", g, 8'h5C);
        @(negedge clk); src_pend = 6'b010_000;
        wr_reg(2'd1, 8'h02); rd_reg(2'd1, g); check("R7 B-tx code", g, 8'h50);
        // R10: B ext pending but disabled drops irq
        @(negedge clk); src_pend = 6'b001_000;
        sample_irq("R10 fall", 1'b0, 1'b1);
        wr_reg(2'd1, 8'h02); rd_reg(2'd1, g); check("R7 no enabled source", g, 8'h56);

        // R9: register 0 status per channel
        rd_reg(2'd0, g); check("R9 A status", g, 8'h00);
        rd_reg(2'd1, g); check("R9 B status", g, 8'h01);

        // R8: master enable off blocks irq
        wr_reg(2'd0, 8'h09); wr_reg(2'd0, 8'h00);
        @(negedge clk); src_pend = 6'b000_010;
        sample_irq("R8 MIE off", 1'b0, 1'b0);
        sample_irq("R8 MIE off hold", 1'b0, 1'b0);

        // R12: both strobes -> write only
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 8'h44;
        #1 check("R12 no read data", rdata, 8'h00);
        @(posedge clk); #1 cs = 1'b0; rd = 1'b0; wr = 1'b0;
        rd_reg(2'd2, g); check("R12 write taken", g, 8'h44);
        // R12: strobe without chip select ignored
        @(negedge clk);
        cs = 1'b0; wr = 1'b1; addr = 2'd2; wdata = 8'hEE;
        @(posedge clk); #1 wr = 1'b0;
        rd_reg(2'd2, g); check("R12 cs low ignored", g, 8'h44);

        // R3: reset with irq active
        wr_reg(2'd1, 8'h09); wr_reg(2'd1, 8'h08);
        @(negedge clk); @(negedge clk); #1;
        check("R10 irq back on", {7'b0, irq}, 8'h01);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #1;
        check("R3 irq cleared", {7'b0, irq}, 8'h00);
        check("R3 no strobe", {7'b0, irq_chg}, 8'h00);
        @(negedge clk); rst = 1'b0;
        sample_irq("R3 quiet after reset", 1'b0, 1'b0);
        wr_reg(2'd0, 8'h01); rd_reg(2'd0, g); check("R3 A reg1 cleared", g, 8'h00);
        wr_reg(2'd0, 8'h02); rd_reg(2'd0, g); check("R3 vector cleared", g, 8'h00);
        rd_reg(2'd2, g); check("R3 data cleared", g, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule